// File: doc/BRIEF.md
# Serial Register Access Slave

This block lets an external host read and write a bank of byte-wide registers over a four-wire serial link made of chip select, serial clock, data in and data out. All three host inputs are brought into the system clock domain through two-stage synchronizers. Every bit event is then found by comparing the synchronized clock with its value one cycle earlier, so the host clock must be slow relative to the system clock. Each half period of the serial clock must last at least four system clock cycles.

A transfer opens when chip select falls. The first byte is a command. Its top bit picks the direction and its remaining seven bits name the register. One or more data bytes follow, and each completed byte moves the register pointer forward by one, wrapping at the top of the space. The register bank can ask for the pointer to stay where it is.

On the inside the block drives a simple register bus: an index, write data, a one-cycle write strobe, a one-cycle read strobe, and read data sampled in the strobe cycle together with a location-valid flag. On the outside the block drives the serial output and its tri-state enable. The enable stays low until a full byte from a valid location is ready to be shifted out.

Top module: `spi_reg_engine`

## Requirements
- R1: While chip select is high, the clock and data inputs have no effect: no strobe is issued and the output enable stays low.
- R2: The first byte after chip select falls is a command byte. Bit 7 set to 1 makes the transfer a write and bit 7 at 0 makes it a read. Bits 6..0 give the starting register index, so register N is written with command N+0x80 and read with command N. A write transfer never raises the output enable.
- R3: Bits move most significant first, eight clocks per byte. When the eighth bit of a write data byte is latched, the block issues exactly one one-cycle write strobe, carrying the assembled byte and the current index.
- R4: The clock level sampled when chip select falls sets the polarity for the whole transfer. Input bits are latched on the clock edge that returns to that idle level. Output bits change on the edge that leaves it. Both idle-low and idle-high hosts are served, with no configuration.
- R5: The output enable stays low through the whole command byte. In a read, it rises on the first leading edge of a data byte, at the same moment as bit 7 of that byte appears.
- R6: If the bank reports the location as invalid (reg_valid_i low) in a read strobe cycle, the output enable stays low for the whole of the matching data byte.
- R7: After each completed data byte the index increases by one, wrapping from 0x7F to 0x00, so that a burst reaches consecutive registers.
- R8: If reg_hold_i is high in the cycle in which the index would advance, the index keeps its value, and the next byte of the burst uses the same register.
- R9: If chip select rises part way through a byte, that byte is dropped, no write strobe is issued, and the next transfer starts cleanly from a new command byte.
- R10: In a read, a one-cycle read strobe is issued after the command byte and after every completed data byte while chip select stays low. A read of N data bytes therefore produces N+1 strobes. The read data is sampled in the strobe cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n_i | input | 1 | Host chip select, active low |
| sclk_i | input | 1 | Host serial clock |
| mosi_i | input | 1 | Serial data from the host |
| miso_o | output | 1 | Serial data to the host |
| miso_oe_o | output | 1 | Tri-state enable for miso_o |
| reg_idx_o | output | 7 | Register index |
| reg_wdata_o | output | 8 | Register write data |
| reg_wr_o | output | 1 | One-cycle write strobe |
| reg_rd_o | output | 1 | One-cycle read strobe |
| reg_rdata_i | input | 8 | Register read data, sampled in the read strobe cycle |
| reg_valid_i | input | 1 | Location at reg_idx_o exists |
| reg_hold_i | input | 1 | Keep the index at its current value |

## Verification
A bit counter that has slipped shows up as a strobe or a read byte displaced by whole bit positions, so the very next data byte either reads back wrong or lands in the wrong register. A polarity latched wrongly at chip-select fall is just as quick to show: every bit of that transfer is taken on the opposite edge, and the first compare fails. An index that moves wrongly, or fails to hold, only appears one byte later, so the bursts compare every byte against a bank model kept in the bench. A stale enable is caught within a single command byte, because the enable is sampled after every leading edge.

// File: rtl/spi_reg_pkg.sv
package spi_reg_pkg;
  // Transfer phase: waiting for chip select, command byte, data bytes
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_ADDR = 2'd1,
    PH_DATA = 2'd2
  } phase_e;
endpackage

// File: rtl/spi_sync.sv
module spi_sync #(
  parameter int            W       = 1,
  parameter int            STAGES  = 2,
  parameter logic [W-1:0]  RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] stg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg <= {STAGES{RST_VAL}};
    end else begin
      stg[0] <= d;
      for (int s = 1; s < STAGES; s++) stg[s] <= stg[s-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/spi_edge.sv
module spi_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_s,
  input  logic sclk_s,
  output logic active,
  output logic cs_fall,
  output logic cpol,
  output logic latch_ev,
  output logic shift_ev
);
  logic cs_d, sclk_d, cpol_q, sclk_chg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_d   <= 1'b1;
      sclk_d <= 1'b0;
      cpol_q <= 1'b0;
    end else begin
      cs_d   <= cs_s;
      sclk_d <= sclk_s;
      if (cs_fall) cpol_q <= sclk_s;
    end
  end

  assign active   = ~cs_s;
  assign cs_fall  = cs_d & ~cs_s;
  // the idle level seen at the select edge decides the polarity
  assign cpol     = cs_fall ? sclk_s : cpol_q;
  assign sclk_chg = sclk_s ^ sclk_d;
  // an edge returning to idle latches, an edge leaving idle shifts
  assign latch_ev = active & sclk_chg & (sclk_s == cpol);
  assign shift_ev = active & sclk_chg & (sclk_s != cpol);
endmodule

// File: rtl/spi_reg_engine.sv
module spi_reg_engine
  import spi_reg_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n_i,
  input  logic              sclk_i,
  input  logic              mosi_i,
  output logic              miso_o,
  output logic              miso_oe_o,
  output logic [DATA_W-2:0] reg_idx_o,
  output logic [DATA_W-1:0] reg_wdata_o,
  output logic              reg_wr_o,
  output logic              reg_rd_o,
  input  logic [DATA_W-1:0] reg_rdata_i,
  input  logic              reg_valid_i,
  input  logic              reg_hold_i
);
  localparam int IDX_W = DATA_W - 1;
  localparam int CNT_W = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);

  function automatic logic [IDX_W-1:0] next_index(input logic [IDX_W-1:0] i,
                                                  input logic h);
    return h ? i : i + 1'b1;
  endfunction

  function automatic logic cmd_is_write(input logic [DATA_W-1:0] b);
    return b[DATA_W-1];
  endfunction

  // synchronized host pins
  logic cs_s, sclk_s, din_s;
  spi_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d({cs_n_i, sclk_i, mosi_i}),
    .q({cs_s, sclk_s, din_s})
  );

  // named events for the checker
  logic xfer_active, cs_fall, cpol, latch_ev, shift_ev, byte_done;
  spi_edge u_edge (
    .clk(clk), .rst_n(rst_n), .cs_s(cs_s), .sclk_s(sclk_s),
    .active(xfer_active), .cs_fall(cs_fall), .cpol(cpol),
    .latch_ev(latch_ev), .shift_ev(shift_ev)
  );

  phase_e              phase_q;
  logic [CNT_W-1:0]    bit_cnt_q;
  logic [DATA_W-1:0]   rx_sr_q, rx_next, tx_sr_q, wdata_q;
  logic [IDX_W-1:0]    idx_q;
  logic                is_wr_q, step_q, rd_q, wr_q, out_q, oe_q, rd_valid_q;
  logic                bit_ev;

  assign bit_ev    = latch_ev && (phase_q != PH_IDLE);
  assign rx_next   = {rx_sr_q[DATA_W-2:0], din_s};
  assign byte_done = bit_ev && (bit_cnt_q == LAST_BIT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q    <= PH_IDLE;
      bit_cnt_q  <= '0;
      rx_sr_q    <= '0;
      tx_sr_q    <= '0;
      wdata_q    <= '0;
      idx_q      <= '0;
      is_wr_q    <= 1'b0;
      step_q     <= 1'b0;
      rd_q       <= 1'b0;
      wr_q       <= 1'b0;
      out_q      <= 1'b0;
      oe_q       <= 1'b0;
      rd_valid_q <= 1'b0;
    end else begin
      wr_q   <= 1'b0;
      rd_q   <= 1'b0;
      step_q <= 1'b0;
      if (!xfer_active) begin
        phase_q    <= PH_IDLE;
        bit_cnt_q  <= '0;
        oe_q       <= 1'b0;
        rd_valid_q <= 1'b0;
      end else begin
        if (cs_fall) begin
          phase_q   <= PH_ADDR;
          bit_cnt_q <= '0;
        end
        if (bit_ev) begin
          rx_sr_q   <= rx_next;
          bit_cnt_q <= byte_done ? '0 : bit_cnt_q + 1'b1;
        end
        if (byte_done) begin
          if (phase_q == PH_ADDR) begin
            is_wr_q <= cmd_is_write(rx_next);
            idx_q   <= rx_next[IDX_W-1:0];
            phase_q <= PH_DATA;
            rd_q    <= !cmd_is_write(rx_next);
          end else begin
            step_q <= 1'b1;
            if (is_wr_q) begin
              wr_q    <= 1'b1;
              wdata_q <= rx_next;
            end
          end
        end
        if (step_q) begin
          idx_q <= next_index(idx_q, reg_hold_i);
          rd_q  <= !is_wr_q;
        end
        if (rd_q) begin
          tx_sr_q    <= reg_rdata_i;
          rd_valid_q <= reg_valid_i;
        end
        if (shift_ev && (phase_q == PH_DATA) && !is_wr_q) begin
          out_q   <= tx_sr_q[DATA_W-1];
          tx_sr_q <= {tx_sr_q[DATA_W-2:0], 1'b0};
          oe_q    <= rd_valid_q;
        end
      end
    end
  end

  assign miso_o      = out_q;
  assign miso_oe_o   = oe_q;
  assign reg_idx_o   = idx_q;
  assign reg_wdata_o = wdata_q;
  assign reg_wr_o    = wr_q;
  assign reg_rd_o    = rd_q;
endmodule

module spi_reg_checker #(
  parameter int IDX_W = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic             xfer_active,
  input logic             cpol,
  input logic             latch_ev,
  input logic             shift_ev,
  input logic             is_wr,
  input logic             step,
  input logic             hold,
  input logic [IDX_W-1:0] idx,
  input logic             miso_oe,
  input logic             reg_wr,
  input logic             reg_rd
);
  AST_IDLE_HIZ: assert property (@(posedge clk) disable iff (!rst_n)
    (!xfer_active && !$past(xfer_active)) |-> !miso_oe); // R1
  AST_NO_WR_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!xfer_active && !$past(xfer_active)) |-> !reg_wr); // R9
  AST_WRITE_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    miso_oe |-> !is_wr); // R2
  AST_WR_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr |=> !reg_wr); // R3
  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr && reg_rd)); // R3
  AST_CPOL_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_active && $past(xfer_active)) |-> $stable(cpol)); // R4
  AST_EDGE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(latch_ev && shift_ev)); // R4
  AST_IDX_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !hold && xfer_active) |=> (idx == IDX_W'($past(idx) + 1'b1))); // R7
  AST_IDX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (step && hold && xfer_active) |=> $stable(idx)); // R8
  AST_RD_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd |=> !reg_rd); // R10
endmodule

bind spi_reg_engine spi_reg_checker #(.IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .xfer_active(xfer_active), .cpol(cpol),
  .latch_ev(latch_ev), .shift_ev(shift_ev), .is_wr(is_wr_q), .step(step_q),
  .hold(reg_hold_i), .idx(reg_idx_o), .miso_oe(miso_oe_o),
  .reg_wr(reg_wr_o), .reg_rd(reg_rd_o)
);

// File: tb/sim_spi_reg_engine.sv
module sim_spi_reg_engine;
  localparam int H = 8;  // system clocks per serial half period

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1, sclk = 1'b0, mosi = 1'b0;
  logic miso, miso_oe, reg_wr, reg_rd, reg_valid, reg_hold;
  logic [6:0] reg_idx;
  logic [7:0] reg_wdata, reg_rdata;

  always #5 clk = ~clk;

  spi_reg_engine u0 (
    .clk(clk), .rst_n(rst_n), .cs_n_i(cs_n), .sclk_i(sclk), .mosi_i(mosi),
    .miso_o(miso), .miso_oe_o(miso_oe), .reg_idx_o(reg_idx),
    .reg_wdata_o(reg_wdata), .reg_wr_o(reg_wr), .reg_rd_o(reg_rd),
    .reg_rdata_i(reg_rdata), .reg_valid_i(reg_valid), .reg_hold_i(reg_hold)
  );

  // register bank model: 0x00..0x5F exist, 0x50 keeps the pointer
  logic [7:0] bank [0:127];
  logic [7:0] exp_mem [0:127];
  int wr_cnt = 0, rd_cnt = 0;
  assign reg_rdata = bank[reg_idx];
  assign reg_valid = (reg_idx < 7'h60);
  assign reg_hold  = (reg_idx == 7'h50);

  always @(posedge clk) begin
    if (reg_wr) begin
      bank[reg_idx] <= reg_wdata;
      wr_cnt <= wr_cnt + 1;
    end
    if (reg_rd) rd_cnt <= rd_cnt + 1;
  end

  int n_chk = 0, n_err = 0;
  logic [7:0] tx_buf [0:15];
  logic [7:0] rx_buf [0:15];
  logic       oe_any [0:15];
  logic       oe_all [0:15];

  task automatic chk(input string req, input string what, input int act, input int expv);
    n_chk++;
    if (act != expv) begin
      n_err++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  task automatic clocks(input int n);
    repeat (n) @(negedge clk);
  endtask

  // nb bytes including the command; cut>0 stops after that many bits
  task automatic xfer(input logic pol, input int nb, input int cut);
    int total;
    total = (cut > 0) ? cut : nb * 8;
    for (int i = 0; i < 16; i++) begin
      oe_any[i] = 1'b0;
      oe_all[i] = 1'b1;
      rx_buf[i] = 8'h00;
    end
    sclk = pol;
    clocks(4);
    cs_n = 1'b0;
    clocks(H);
    for (int b = 0; b < total; b++) begin
      sclk = ~pol;
      mosi = tx_buf[b/8][7 - (b % 8)];
      clocks(H);
      rx_buf[b/8][7 - (b % 8)] = miso;
      oe_any[b/8] = oe_any[b/8] | miso_oe;
      oe_all[b/8] = oe_all[b/8] & miso_oe;
      sclk = pol;
      clocks(H);
    end
    clocks(H);
    cs_n = 1'b1;
    clocks(4 * H);
  endtask

  function automatic logic [7:0] pat(input int i);
    return 8'((i * 37) ^ 8'h5A);
  endfunction

  initial begin
    int w0, r0;
    for (int i = 0; i < 128; i++) begin
      bank[i] = 8'h00;
      exp_mem[i] = 8'h00;
    end
    clocks(5);
    rst_n = 1'b1;
    clocks(4);
    chk("R1", "reset oe", miso_oe, 0);
    chk("R1", "reset wr strobe", reg_wr, 0);

    // R1: activity with select high is ignored
    for (int k = 0; k < 20; k++) begin
      sclk = ~sclk;
      mosi = k[1];
      clocks(H);
      if (miso_oe) chk("R1", "oe while deselected", 1, 0);
    end
    chk("R1", "no write strobe while deselected", wr_cnt, 0);
    chk("R1", "no read strobe while deselected", rd_cnt, 0);

    // R2 R3 R4: single-byte write to every register, polarity alternating
    for (int i = 0; i < 128; i++) begin
      w0 = wr_cnt;
      tx_buf[0] = 8'h80 | 8'(i);
      tx_buf[1] = pat(i);
      xfer(i[0], 2, 0);
      exp_mem[i] = pat(i);
      chk("R3", $sformatf("write reg %0h", i), bank[i], exp_mem[i]);
      chk("R3", "one write strobe", wr_cnt - w0, 1);
      chk("R2", "write never drives", oe_any[0] | oe_any[1], 0);
    end

    // R4 R5 R6 R10: single-byte read of every register
    for (int i = 0; i < 128; i++) begin
      r0 = rd_cnt;
      tx_buf[0] = 8'(i);
      tx_buf[1] = 8'h00;
      xfer(~i[0], 2, 0);
      chk("R5", "oe low in command byte", oe_any[0], 0);
      chk("R10", "read strobes for one byte", rd_cnt - r0, 2);
      if (i < 'h60) begin
        chk("R5", "oe held for read byte", oe_all[1], 1);
        chk("R4", $sformatf("read reg %0h", i), rx_buf[1], exp_mem[i]);
      end else begin
        chk("R6", $sformatf("invalid reg %0h stays hi-z", i), oe_any[1], 0);
      end
    end

    // R7: write burst then read burst
    tx_buf[0] = 8'h88;
    for (int k = 0; k < 6; k++) tx_buf[1+k] = 8'hA0 + 8'(k);
    xfer(1'b0, 7, 0);
    for (int k = 0; k < 6; k++) begin
      exp_mem[8+k] = 8'hA0 + 8'(k);
      chk("R7", "burst write", bank[8+k], exp_mem[8+k]);
    end
    r0 = rd_cnt;
    tx_buf[0] = 8'h08;
    xfer(1'b1, 7, 0);
    for (int k = 0; k < 6; k++) chk("R7", "burst read", rx_buf[1+k], exp_mem[8+k]);
    chk("R10", "read strobes for six bytes", rd_cnt - r0, 7);

    // R7: wrap from the top index to zero
    tx_buf[0] = 8'hFE;
    tx_buf[1] = 8'h11; tx_buf[2] = 8'h22; tx_buf[3] = 8'h33;
    xfer(1'b1, 4, 0);
    exp_mem[126] = 8'h11; exp_mem[127] = 8'h22; exp_mem[0] = 8'h33;
    chk("R7", "wrap 7E", bank[126], exp_mem[126]);
    chk("R7", "wrap 7F", bank[127], exp_mem[127]);
    chk("R7", "wrap 00", bank[0], exp_mem[0]);

    // R8: pointer held at 0x50
    tx_buf[0] = 8'hCF;
    tx_buf[1] = 8'h61; tx_buf[2] = 8'h62; tx_buf[3] = 8'h63; tx_buf[4] = 8'h64;
    xfer(1'b0, 5, 0);
    exp_mem[79] = 8'h61; exp_mem[80] = 8'h64;
    chk("R8", "before hold", bank[79], exp_mem[79]);
    chk("R8", "held register last byte", bank[80], exp_mem[80]);
    chk("R8", "next register untouched", bank[81], exp_mem[81]);
    tx_buf[0] = 8'h50;
    xfer(1'b1, 4, 0);
    for (int k = 1; k < 4; k++) chk("R8", "held read", rx_buf[k], exp_mem[80]);

    // R9: select rises mid data byte, then mid command byte
    w0 = wr_cnt;
    tx_buf[0] = 8'h90; tx_buf[1] = 8'hC3;
    xfer(1'b1, 2, 13);
    chk("R9", "partial byte dropped", bank[16], exp_mem[16]);
    chk("R9", "no strobe for partial byte", wr_cnt - w0, 0);
    xfer(1'b0, 2, 4);
    chk("R9", "partial command no strobe", wr_cnt - w0, 0);
    tx_buf[0] = 8'h90; tx_buf[1] = 8'h3C;
    xfer(1'b0, 2, 0);
    exp_mem[16] = 8'h3C;
    chk("R9", "clean restart", bank[16], exp_mem[16]);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    $finish;
  end
endmodule